// File: doc/BRIEF.md
# Indexed Operand Address Generator

This block turns an indexed-addressing postbyte into the effective operand address for a 16-bit microcontroller core. On a `start` pulse it captures the postbyte, the index registers (X, Y, SP, PC) and the two 8-bit accumulators. It classifies the form, takes zero, one or two extension bytes over a valid/ready channel, and issues at most one 16-bit pointer read over a request/response channel. It finishes with a one-cycle `done` pulse that carries the address.

Auto-modify forms also report a write-back of the new index value, so the core can update X, Y or SP. A `restricted` input locks out the long-offset and extension-indirect forms. When it blocks a form, the block returns address zero and raises an error flag instead of fetching anything. Instruction fetch, operand access and execution stay with the surrounding core.

Top module: `idx_addr_gen`

## Requirements
- R1: After reset `done`, `busy`, `ext_ready`, `rd_req_valid`, `rd_rsp_ready` and `wb_en` are all 0.
- R2: Postbyte bit 5 = 0 selects a constant-offset form. The base is chosen by bits 7:6 (0 = X, 1 = Y, 2 = SP, 3 = PC). The address is base plus bits 4:0 sign-extended from bit 4, modulo 2^16.
- R3: Bit 5 = 1 with bits 7:6 not equal to 3 selects auto-modify. The step is the low nibble sign-extended (-8..-1) when nibble bit 3 is set, and nibble+1 (1..8) otherwise. With `done`, `wb_en` = 1, `wb_sel` = bits 7:6, and `wb_val` = base + step.
- R4: In auto-modify, bit 4 = 0 (pre) gives the updated value as the address. Bit 4 = 1 (post) gives the original base.
- R5: Bits 7:6 = 3 choose the base with bits 4:3. If bit 2 = 0 and bits 2:0 are not 011, bit 1 = 1 adds a 16-bit offset made of two extension bytes, high byte first. Bit 1 = 0 adds one extension byte, and postbyte bit 0 gives it a 9th (sign) bit.
- R6: Bits 7:6 = 3 and bits 2:0 = 100, 101 or 110 add A, B (each zero-extended) or D = {A, B} (A high byte) to the base.
- R7: Bits 7:6 = 3 and bits 2:0 = 011 add a two-byte extension offset to the base. The block then reads a 16-bit word at that sum, and the word read is the address.
- R8: Bits 7:6 = 3 and bits 2:0 = 111 read a 16-bit word at base + D, and the word read is the address. No extension byte is taken.
- R9: With `restricted` = 1, the 9-bit, 16-bit and 16-bit-indirect forms complete with address 0 and `err` = 1. They take no extension byte, issue no read and do no write-back. All other forms are unaffected and give `err` = 0.
- R10: `extra_cyc` is 1 with `done` exactly for the 9-bit, 16-bit, 16-bit-indirect and D-indirect forms that complete without error.
- R11: An extension byte is consumed only in a cycle with `ext_valid` and `ext_ready` both high. A read request holds `rd_req_valid` and `rd_addr` steady until `rd_req_ready`. Exactly the number of bytes and reads the form needs are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode; taken only while not busy |
| postbyte | input | 8 | Indexed-mode postbyte |
| restricted | input | 1 | Forbid long-offset and extension-indirect forms |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter value used as base |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| ext_valid | input | 1 | Extension byte present |
| ext_byte | input | 8 | Extension byte |
| ext_ready | output | 1 | Block waiting for an extension byte |
| rd_req_valid | output | 1 | Pointer read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | 16 | Pointer read address |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_ready | output | 1 | Block waiting for read data |
| rd_data | input | 16 | Pointer word read |
| busy | output | 1 | A decode is in progress |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Effective address, valid with `done` |
| err | output | 1 | Restricted-form violation, valid with `done` |
| extra_cyc | output | 1 | Form costs one extra cycle, valid with `done` |
| wb_en | output | 1 | Index write-back, pulses with `done` |
| wb_sel | output | 2 | Write-back register (0 X, 1 Y, 2 SP) |
| wb_val | output | 16 | Write-back value |

## Verification
All 256 postbytes are run with `restricted` both low and high, against three register sets. One set places bases near 0xFFFF and 0x0000 and uses accumulators with the top bit set, which separates wraparound and zero-extension from sign-extension. The extension bytes and the pointer-memory contents depend on the postbyte and the set, so swapped byte order, a wrong sign bit or a read from the wrong address each give a different address. On selected postbytes the bench holds back `ext_valid` or `rd_req_ready` for one cycle. This shows whether the block consumes only on a real handshake.

// File: rtl/idx_pkg.sv
`timescale 1ns/1ps
package idx_pkg;
   localparam int PB_W = 8;

   typedef enum logic [2:0] {
      F_CONST  = 3'd0,
      F_AUTO   = 3'd1,
      F_OFF9   = 3'd2,
      F_OFF16  = 3'd3,
      F_IND16  = 3'd4,
      F_ACC    = 3'd5,
      F_ACCIND = 3'd6
   } idx_form_e;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_EXT0   = 3'd1,
      S_EXT1   = 3'd2,
      S_RDREQ  = 3'd3,
      S_RDWAIT = 3'd4
   } idx_state_e;
endpackage

// File: rtl/idx_decode.sv
`timescale 1ns/1ps
module idx_decode
   import idx_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [PB_W-1:0] pb,
   output idx_form_e       form,
   output logic [1:0]      base_sel,
   output logic [AW-1:0]   off5,
   output logic [AW-1:0]   step,
   output logic            post,
   output logic [1:0]      acc_sel,
   output logic            sgn
);
   localparam int NIB = 4;

   logic long_grp;
   assign long_grp = (pb[7:6] == 2'b11);

   always_comb begin
      if (!pb[5])                 form = F_CONST;
      else if (!long_grp)         form = F_AUTO;
      else if (pb[2:0] == 3'b011) form = F_IND16;
      else if (!pb[2])            form = pb[1] ? F_OFF16 : F_OFF9;
      else if (pb[1:0] == 2'b11)  form = F_ACCIND;
      else                        form = F_ACC;
   end

   // Constant and auto-modify forms index by the top two bits; the long group by bits 4:3.
   assign base_sel = (pb[5] && long_grp) ? pb[4:3] : pb[7:6];
   assign off5     = {{(AW-5){pb[4]}}, pb[4:0]};
   assign step     = pb[3] ? {{(AW-NIB){1'b1}}, pb[NIB-1:0]}
                           : ({{(AW-NIB){1'b0}}, pb[NIB-1:0]} + {{(AW-1){1'b0}}, 1'b1});
   assign post     = pb[4];
   assign acc_sel  = pb[1:0];
   assign sgn      = pb[0];
endmodule

// File: rtl/idx_base_mux.sv
`timescale 1ns/1ps
module idx_base_mux #(
   parameter int AW   = 16,
   parameter int NREG = 4
) (
   input  logic [1:0]    sel,
   input  logic [AW-1:0] r0,
   input  logic [AW-1:0] r1,
   input  logic [AW-1:0] r2,
   input  logic [AW-1:0] r3,
   output logic [AW-1:0] base
);
   logic [AW-1:0] regs [NREG];

   assign regs[0] = r0;
   assign regs[1] = r1;
   assign regs[2] = r2;
   assign regs[3] = r3;
   assign base    = regs[sel];
endmodule

// File: rtl/idx_seq.sv
`timescale 1ns/1ps
module idx_seq
   import idx_pkg::*;
#(
   parameter int AW           = 16,
   parameter int BW           = 8,
   parameter bit EXT_HI_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          restricted,
   input  idx_form_e     form,
   input  logic [1:0]    base_sel,
   input  logic [AW-1:0] base_val,
   input  logic [AW-1:0] off5,
   input  logic [AW-1:0] step,
   input  logic          post,
   input  logic [1:0]    acc_sel,
   input  logic          sgn,
   input  logic [BW-1:0] acc_a,
   input  logic [BW-1:0] acc_b,
   input  logic          ext_valid,
   input  logic [BW-1:0] ext_byte,
   output logic          ext_ready,
   output logic          rd_req_valid,
   input  logic          rd_req_ready,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_rsp_valid,
   output logic          rd_rsp_ready,
   input  logic [AW-1:0] rd_data,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] eff_addr,
   output logic          err,
   output logic          extra_cyc,
   output logic          wb_en,
   output logic [1:0]    wb_sel,
   output logic [AW-1:0] wb_val
);
   localparam int PAD = AW - BW;

   idx_state_e    st_q, st_n;
   idx_form_e     form_q, form_n;
   logic [AW-1:0] base_q, base_n, rda_q, rda_n;
   logic [BW-1:0] hold_q, hold_n;
   logic          sgn_q, sgn_n;

   logic          fin, fin_err, fin_extra, fin_wb;
   logic [AW-1:0] fin_addr;

   logic [AW-1:0] short_sum, auto_sum, acc_off, acc_sum, off9, off16;

   assign short_sum = base_val + off5;
   assign auto_sum  = base_val + step;
   assign acc_sum   = base_val + acc_off;
   assign off9      = {{PAD{sgn_q}}, ext_byte};

   always_comb begin
      unique case (acc_sel)
         2'b00:   acc_off = {{PAD{1'b0}}, acc_a};
         2'b01:   acc_off = {{PAD{1'b0}}, acc_b};
         default: acc_off = {acc_a, acc_b};
      endcase
   end

   // Byte order of the two-byte extension is a build option.
   generate
      if (EXT_HI_FIRST) begin : g_hi_first
         assign off16 = {hold_q, ext_byte};
      end else begin : g_lo_first
         assign off16 = {ext_byte, hold_q};
      end
   endgenerate

   always_comb begin
      st_n      = st_q;
      form_n    = form_q;
      base_n    = base_q;
      rda_n     = rda_q;
      hold_n    = hold_q;
      sgn_n     = sgn_q;
      fin       = 1'b0;
      fin_err   = 1'b0;
      fin_extra = 1'b0;
      fin_wb    = 1'b0;
      fin_addr  = '0;
      unique case (st_q)
         S_IDLE: begin
            if (start) begin
               base_n = base_val;
               form_n = form;
               sgn_n  = sgn;
               unique case (form)
                  F_CONST: begin
                     fin      = 1'b1;
                     fin_addr = short_sum;
                  end
                  F_AUTO: begin
                     fin      = 1'b1;
                     fin_wb   = 1'b1;
                     fin_addr = post ? base_val : auto_sum;
                  end
                  F_ACC: begin
                     fin      = 1'b1;
                     fin_addr = acc_sum;
                  end
                  F_ACCIND: begin
                     rda_n = acc_sum;
                     st_n  = S_RDREQ;
                  end
                  default: begin
                     if (restricted) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                     end else begin
                        st_n = S_EXT0;
                     end
                  end
               endcase
            end
         end
         S_EXT0: begin
            if (ext_valid) begin
               if (form_q == F_OFF9) begin
                  fin       = 1'b1;
                  fin_extra = 1'b1;
                  fin_addr  = base_q + off9;
                  st_n      = S_IDLE;
               end else begin
                  hold_n = ext_byte;
                  st_n   = S_EXT1;
               end
            end
         end
         S_EXT1: begin
            if (ext_valid) begin
               if (form_q == F_OFF16) begin
                  fin       = 1'b1;
                  fin_extra = 1'b1;
                  fin_addr  = base_q + off16;
                  st_n      = S_IDLE;
               end else begin
                  rda_n = base_q + off16;
                  st_n  = S_RDREQ;
               end
            end
         end
         S_RDREQ: begin
            if (rd_req_ready) st_n = S_RDWAIT;
         end
         S_RDWAIT: begin
            if (rd_rsp_valid) begin
               fin       = 1'b1;
               fin_extra = 1'b1;
               fin_addr  = rd_data;
               st_n      = S_IDLE;
            end
         end
         default: st_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         form_q    <= F_CONST;
         base_q    <= '0;
         rda_q     <= '0;
         hold_q    <= '0;
         sgn_q     <= 1'b0;
         done      <= 1'b0;
         eff_addr  <= '0;
         err       <= 1'b0;
         extra_cyc <= 1'b0;
         wb_en     <= 1'b0;
         wb_sel    <= 2'd0;
         wb_val    <= '0;
      end else begin
         st_q   <= st_n;
         form_q <= form_n;
         base_q <= base_n;
         rda_q  <= rda_n;
         hold_q <= hold_n;
         sgn_q  <= sgn_n;
         done   <= fin;
         wb_en  <= fin_wb;
         if (fin) begin
            eff_addr  <= fin_addr;
            err       <= fin_err;
            extra_cyc <= fin_extra;
         end
         if (fin_wb) begin
            wb_sel <= base_sel;
            wb_val <= auto_sum;
         end
      end
   end

   assign ext_ready    = (st_q == S_EXT0) || (st_q == S_EXT1);
   assign rd_req_valid = (st_q == S_RDREQ);
   assign rd_rsp_ready = (st_q == S_RDWAIT);
   assign rd_addr      = rda_q;
   assign busy         = (st_q != S_IDLE);
endmodule

// File: rtl/idx_addr_gen.sv
`timescale 1ns/1ps
module idx_addr_gen
   import idx_pkg::*;
#(
   parameter int AW           = 16,
   parameter int BW           = 8,
   parameter bit EXT_HI_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [PB_W-1:0] postbyte,
   input  logic            restricted,
   input  logic [AW-1:0]   reg_x,
   input  logic [AW-1:0]   reg_y,
   input  logic [AW-1:0]   reg_sp,
   input  logic [AW-1:0]   reg_pc,
   input  logic [BW-1:0]   acc_a,
   input  logic [BW-1:0]   acc_b,
   input  logic            ext_valid,
   input  logic [BW-1:0]   ext_byte,
   output logic            ext_ready,
   output logic            rd_req_valid,
   input  logic            rd_req_ready,
   output logic [AW-1:0]   rd_addr,
   input  logic            rd_rsp_valid,
   output logic            rd_rsp_ready,
   input  logic [AW-1:0]   rd_data,
   output logic            busy,
   output logic            done,
   output logic [AW-1:0]   eff_addr,
   output logic            err,
   output logic            extra_cyc,
   output logic            wb_en,
   output logic [1:0]      wb_sel,
   output logic [AW-1:0]   wb_val
);
   localparam int NREG = 4;

   generate
      if (AW != 2 * BW) begin : g_bad_width
         $error("idx_addr_gen: AW must equal two extension bytes");
      end
      if (BW < 5) begin : g_bad_byte
         $error("idx_addr_gen: BW too narrow for the short offset");
      end
   endgenerate

   idx_form_e     form;
   logic [1:0]    base_sel, acc_sel;
   logic [AW-1:0] off5, step, base_val;
   logic          post, sgn;

   idx_decode #(.AW(AW)) u_dec (
      .pb(postbyte), .form(form), .base_sel(base_sel), .off5(off5),
      .step(step), .post(post), .acc_sel(acc_sel), .sgn(sgn)
   );

   idx_base_mux #(.AW(AW), .NREG(NREG)) u_mux (
      .sel(base_sel), .r0(reg_x), .r1(reg_y), .r2(reg_sp), .r3(reg_pc),
      .base(base_val)
   );

   idx_seq #(.AW(AW), .BW(BW), .EXT_HI_FIRST(EXT_HI_FIRST)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .restricted(restricted),
      .form(form), .base_sel(base_sel), .base_val(base_val), .off5(off5),
      .step(step), .post(post), .acc_sel(acc_sel), .sgn(sgn),
      .acc_a(acc_a), .acc_b(acc_b),
      .ext_valid(ext_valid), .ext_byte(ext_byte), .ext_ready(ext_ready),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
      .rd_rsp_ready(rd_rsp_ready), .rd_data(rd_data),
      .busy(busy), .done(done), .eff_addr(eff_addr), .err(err),
      .extra_cyc(extra_cyc), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
   );
endmodule

// File: rtl/idx_addr_gen_chk.sv
`timescale 1ns/1ps
module idx_addr_gen_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] eff_addr,
   input logic          err,
   input logic          extra_cyc,
   input logic          wb_en,
   input logic [1:0]    wb_sel,
   input logic          ext_ready,
   input logic          rd_req_valid,
   input logic          rd_req_ready,
   input logic [AW-1:0] rd_addr,
   input logic          rd_rsp_ready
);
   p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (eff_addr == '0 && !wb_en));

   p_err_noextra_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> !extra_cyc);

   p_wb_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (done && !err));

   p_wb_not_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_sel != 2'd3));

   p_extra_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && extra_cyc) |-> !wb_en);

   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

   p_chan_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ext_ready, rd_req_valid, rd_rsp_ready}));

   p_wait_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_ready || rd_req_valid || rd_rsp_ready) |-> busy);
endmodule

bind idx_addr_gen idx_addr_gen_chk #(.AW(AW)) i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .eff_addr(eff_addr),
   .err(err), .extra_cyc(extra_cyc), .wb_en(wb_en), .wb_sel(wb_sel),
   .ext_ready(ext_ready), .rd_req_valid(rd_req_valid),
   .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_ready(rd_rsp_ready)
);

// File: tb/test_idx_addr_gen.sv
`timescale 1ns/1ps
module test_idx_addr_gen;
   localparam int AW = 16;
   localparam int BW = 8;
   localparam int WD_CYC = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [7:0]    postbyte = '0;
   logic          restricted = 1'b0;
   logic [AW-1:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
   logic [BW-1:0] acc_a = '0, acc_b = '0;
   logic          ext_valid = 1'b0;
   logic [BW-1:0] ext_byte = '0;
   logic          rd_req_ready = 1'b0;
   logic          rd_rsp_valid = 1'b0;
   logic [AW-1:0] rd_data = '0;
   logic          ext_ready, rd_req_valid, rd_rsp_ready, busy, done;
   logic          err, extra_cyc, wb_en;
   logic [1:0]    wb_sel;
   logic [AW-1:0] rd_addr, eff_addr, wb_val;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   idx_addr_gen i_idx_addr_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
      .restricted(restricted), .reg_x(reg_x), .reg_y(reg_y),
      .reg_sp(reg_sp), .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
      .ext_valid(ext_valid), .ext_byte(ext_byte), .ext_ready(ext_ready),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
      .rd_rsp_ready(rd_rsp_ready), .rd_data(rd_data), .busy(busy),
      .done(done), .eff_addr(eff_addr), .err(err), .extra_cyc(extra_cyc),
      .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s pb=%02h rs=%0d actual=%0h expected=%0h",
                  tag, postbyte, restricted, act, exp);
      end
   endtask

   function automatic logic [15:0] mem_word(input logic [15:0] adr);
      return {adr[7:0] ^ 8'h5A, adr[15:8] + 8'h23};
   endfunction

   function automatic logic [15:0] pick(input logic [1:0] s);
      case (s)
         2'd0: return reg_x;
         2'd1: return reg_y;
         2'd2: return reg_sp;
         default: return reg_pc;
      endcase
   endfunction

   // Reference model written from the requirements.
   task automatic model(input logic [7:0] pb, input logic rs,
                        input logic [7:0] e0, input logic [7:0] e1,
                        output logic [15:0] x_addr, output logic x_err,
                        output logic x_extra, output logic x_wb,
                        output logic [1:0] x_sel, output logic [15:0] x_val,
                        output int x_nb, output int x_nr,
                        output logic [15:0] x_radr, output string tag);
      logic [15:0] base, stp, nv, ptr;
      x_addr = '0; x_err = 0; x_extra = 0; x_wb = 0; x_sel = 0; x_val = 0;
      x_nb = 0; x_nr = 0; x_radr = 0; tag = "R2";
      if (!pb[5]) begin
         x_addr = pick(pb[7:6]) + {{11{pb[4]}}, pb[4:0]};
         tag = "R2";
      end else if (pb[7:6] != 2'b11) begin
         base = pick(pb[7:6]);
         stp  = pb[3] ? {12'hFFF, pb[3:0]} : {12'h000, pb[3:0]} + 16'd1;
         nv   = base + stp;
         x_addr = pb[4] ? base : nv;
         x_wb = 1; x_sel = pb[7:6]; x_val = nv;
         tag = "R4";
      end else begin
         base = pick(pb[4:3]);
         if (pb[2:0] == 3'b011 || !pb[2]) begin
            if (rs) begin
               x_err = 1; tag = "R9";
            end else if (pb[2:0] == 3'b011) begin
               ptr = base + {e0, e1};
               x_nb = 2; x_nr = 1; x_radr = ptr; x_addr = mem_word(ptr);
               x_extra = 1; tag = "R7";
            end else if (pb[1]) begin
               x_nb = 2; x_addr = base + {e0, e1}; x_extra = 1; tag = "R5";
            end else begin
               x_nb = 1; x_addr = base + {{8{pb[0]}}, e0}; x_extra = 1; tag = "R5";
            end
         end else begin
            case (pb[1:0])
               2'b00: begin x_addr = base + {8'h00, acc_a}; tag = "R6"; end
               2'b01: begin x_addr = base + {8'h00, acc_b}; tag = "R6"; end
               2'b10: begin x_addr = base + {acc_a, acc_b}; tag = "R6"; end
               default: begin
                  ptr = base + {acc_a, acc_b};
                  x_nr = 1; x_radr = ptr; x_addr = mem_word(ptr);
                  x_extra = 1; tag = "R8";
               end
            endcase
         end
      end
   endtask

   task automatic run_one(input logic [7:0] pb, input logic rs, input int set);
      logic [7:0] bytes [2];
      logic [15:0] x_addr, x_val, x_radr, rq;
      logic x_err, x_extra, x_wb;
      logic [1:0] x_sel;
      int x_nb, x_nr, nb, nr;
      string tag;
      bit got, stall, waited;
      bytes[0] = pb ^ 8'hC5 ^ 8'(set * 17);
      bytes[1] = pb * 8'd3 + 8'(set);
      stall = pb[1] ^ pb[6] ^ rs;
      model(pb, rs, bytes[0], bytes[1], x_addr, x_err, x_extra, x_wb,
            x_sel, x_val, x_nb, x_nr, x_radr, tag);
      nb = 0; nr = 0; got = 0; waited = 0; rq = '0;
      @(negedge clk);
      postbyte = pb; restricted = rs; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 40 && !got; c++) begin
         if (done) begin
            got = 1;
         end else begin
            ext_valid = 1'b0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
            if (ext_ready) begin
               if (stall && !waited) waited = 1;
               else begin
                  ext_valid = 1'b1; ext_byte = bytes[nb > 1 ? 1 : nb];
                  nb++; waited = 0;
               end
            end
            if (rd_req_valid) begin
               if (stall && !waited) waited = 1;
               else begin
                  rd_req_ready = 1'b1; rq = rd_addr; nr++; waited = 0;
               end
            end
            if (rd_rsp_ready) begin
               rd_rsp_valid = 1'b1; rd_data = mem_word(rq);
            end
            @(negedge clk);
         end
      end
      ext_valid = 1'b0; rd_req_ready = 1'b0; rd_rsp_valid = 1'b0;
      chk("R11 done seen", 32'(got), 32'd1);
      chk(tag, 32'(eff_addr), 32'(x_addr));
      chk("R9 err", 32'(err), 32'(x_err));
      chk("R10 extra", 32'(extra_cyc), 32'(x_extra));
      chk("R3 wb_en", 32'(wb_en), 32'(x_wb));
      if (x_wb) begin
         chk("R3 wb_sel", 32'(wb_sel), 32'(x_sel));
         chk("R3 wb_val", 32'(wb_val), 32'(x_val));
      end
      chk("R11 bytes", 32'(nb), 32'(x_nb));
      chk("R11 reads", 32'(nr), 32'(x_nr));
      if (x_nr != 0) chk("R7/R8 read addr", 32'(rq), 32'(x_radr));
   endtask

   initial begin
      #(WD_CYC * 8);
      if (!finished) begin
         n_bad++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle outputs while and just after reset.
      chk("R1 done", 32'(done), 0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 chans", 32'({ext_ready, rd_req_valid, rd_rsp_ready}), 0);
      chk("R1 wb_en", 32'(wb_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'({done, busy, ext_ready, rd_req_valid}), 0);
      for (int set = 0; set < 3; set++) begin
         case (set)
            0: begin reg_x = 16'h1234; reg_y = 16'h4000; reg_sp = 16'h0F00;
                     reg_pc = 16'hC010; acc_a = 8'h12; acc_b = 8'h34; end
            1: begin reg_x = 16'hFFFE; reg_y = 16'h0001; reg_sp = 16'h8000;
                     reg_pc = 16'h7FFF; acc_a = 8'hFF; acc_b = 8'h80; end
            default: begin reg_x = 16'h0000; reg_y = 16'hFFFF; reg_sp = 16'h00FF;
                     reg_pc = 16'h0100; acc_a = 8'h81; acc_b = 8'hF7; end
         endcase
         for (int rs = 0; rs < 2; rs++)
            for (int pb = 0; pb < 256; pb++)
               run_one(8'(pb), rs[0], set);
      end
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule